// File: doc/BRIEF.md
# Packet Header Match Filter for Layer 3 and Layer 4 Fields

This block classifies one packet per strobe against a bank of programmable filter entries. A header parser upstream supplies the packet's fields together with a one-cycle valid strobe. These fields are the IP version, the source and destination addresses, the transport protocol and the two port numbers. Each entry has three configuration words: a control word, a port word and a 128-bit address word. The control word enables an address comparison and a port comparison for each direction, and each comparison can be inverted. It also picks IPv4 or IPv6 matching, picks TCP or UDP for the ports, and sets a count of low address bits to ignore.

One cycle after the strobe the block presents a per-entry hit vector and a drop decision, with a one-cycle result strobe. A two-state machine sequences the result. In `S_IDLE` no result is shown. The transition `IDLE_TO_REPORT` is taken on a packet strobe and enters `S_REPORT`, where the registered result is shown. `REPORT_HOLD` stays in `S_REPORT` when another strobe arrives straight away. `REPORT_TO_IDLE` returns to `S_IDLE` when no strobe arrives. Filtering as a whole is gated by an enable bit in a packet-filter configuration word.

Top module: `l3l4_match_filter`

## Requirements
- R1: `res_valid` is high exactly in the cycle after each cycle with `pkt_valid` high. While `res_valid` is low, `res_hit` and `res_drop` are zero.
- R2: Bit 20 of `cfg_pkt_filter` is the global enable. When it is clear, a result has `res_hit` all zero and `res_drop` low. The result strobe still appears.
- R3: An entry whose control word is all zero never hits. An entry that enables none of its four comparisons (control bits 2, 4, 18, 20) also never hits.
- R4: Control bit 0 selects the address mode: 1 for IPv6, 0 for IPv4. An address comparison matches only if `pkt_v6` equals the mode bit. In IPv4 mode the source is compared with address word bits [31:0] and the destination with bits [63:32], using the low 32 packet address bits. In IPv6 mode the whole 128-bit address word is compared.
- R5: Control bits [10:6] (source) and [15:11] (destination) hold a count k. The comparison ignores the k least significant address bits.
- R6: Control bit 2 enables the source address comparison and bit 3 inverts its result. Bits 4 and 5 do the same for the destination address.
- R7: An entry in IPv6 mode with both source and destination address comparisons enabled never hits.
- R8: Control bit 16 selects UDP (1) or TCP (0). Bits 18/19 enable and invert the source port comparison, and bits 20/21 do the same for the destination port. The port word holds the destination port in [31:16] and the source port in [15:0]. A port comparison matches only if `pkt_l4` equals the selected protocol, where 2'b01 is TCP, 2'b10 is UDP and other codes are neither.
- R9: An entry hits only when every comparison it enables passes after its inversion.
- R10: With filtering enabled, `res_drop` is high when some entry has an enabled, inverted comparison and does not hit. Otherwise `res_drop` is low.
- R11: Strobes on consecutive cycles each give their own result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pkt_filter | input | 32 | Packet-filter configuration word; bit 20 is the global enable |
| cfg_ctrl | input | 32*NUM_FILT | Control words, entry i in bits [32i+31:32i] |
| cfg_port | input | 32*NUM_FILT | Port words, entry i in bits [32i+31:32i] |
| cfg_addr | input | 128*NUM_FILT | Address words, entry i in bits [128i+127:128i] |
| pkt_valid | input | 1 | Header fields valid this cycle |
| pkt_v6 | input | 1 | Packet is IPv6 |
| pkt_l4 | input | 2 | Transport protocol code: 01 TCP, 10 UDP |
| pkt_src_addr | input | 128 | Source address (IPv4 in [31:0]) |
| pkt_dst_addr | input | 128 | Destination address (IPv4 in [31:0]) |
| pkt_src_port | input | 16 | Source port |
| pkt_dst_port | input | 16 | Destination port |
| res_valid | output | 1 | Result strobe |
| res_hit | output | NUM_FILT | Per-entry hit vector |
| res_drop | output | 1 | Drop decision |

## Verification
The hardest situation to reach from the ports is a packet that lines up with one entry on every enabled field at once. That means the same version, the same protocol and equal addresses above the mask count. Independent random headers almost never produce one. The stimulus therefore builds most random packets from a chosen entry's own configuration and then disturbs a few low address bits or the protocol. This lands packets on both sides of the mask boundary and of the inversion. Directed cases cover the IPv6 dual-enable conflict and entries that are nonzero but enable no comparison.

// File: rtl/l3l4_filt_pkg.sv
package l3l4_filt_pkg;

    typedef enum logic [1:0] {
        L4_OTHER = 2'b00,
        L4_TCP   = 2'b01,
        L4_UDP   = 2'b10,
        L4_RSVD  = 2'b11
    } l4_kind_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_REPORT = 1'b1
    } rep_state_e;

    // Control word bit positions
    localparam int CB_V6       = 0;
    localparam int CB_SA_EN    = 2;
    localparam int CB_SA_INV   = 3;
    localparam int CB_DA_EN    = 4;
    localparam int CB_DA_INV   = 5;
    localparam int CB_SMASK_LO = 6;
    localparam int CB_DMASK_LO = 11;
    localparam int CB_UDP      = 16;
    localparam int CB_SP_EN    = 18;
    localparam int CB_SP_INV   = 19;
    localparam int CB_DP_EN    = 20;
    localparam int CB_DP_INV   = 21;
    localparam int MASK_W      = 5;

    localparam int GLOBAL_EN_BIT = 20;

    // Keep-mask: ones above the k ignored low bits
    function automatic logic [127:0] keep_above(input logic [MASK_W-1:0] k);
        logic [127:0] ones;
        ones = '1;
        return ones << k;
    endfunction

endpackage

// File: rtl/l3l4_addr_cmp.sv
module l3l4_addr_cmp
    import l3l4_filt_pkg::*;
#(
    parameter int ADDR_W = 128,
    parameter int V4_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_v6,
    input  logic              pkt_v6,
    input  logic [ADDR_W-1:0] pkt_addr,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [MASK_W-1:0] mask_k,
    input  logic              inv,
    output logic              pass
);
    logic [ADDR_W-1:0] width_keep;
    logic [ADDR_W-1:0] low_keep;
    logic [ADDR_W-1:0] diff;
    logic              ver_ok;
    logic              raw;

    always_comb begin
        width_keep = mode_v6 ? '1 : {{(ADDR_W-V4_W){1'b0}}, {V4_W{1'b1}}};
        low_keep   = keep_above(mask_k);
        diff       = (pkt_addr ^ ref_addr) & width_keep & low_keep;
        ver_ok     = (mode_v6 == pkt_v6);
        raw        = ver_ok && (diff == '0);
        pass       = raw ^ inv;
    end

    // R4
    ver_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_v6 != pkt_v6) |-> (pass == inv));

endmodule

// File: rtl/l3l4_port_cmp.sv
module l3l4_port_cmp
    import l3l4_filt_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_udp,
    input  logic [1:0]        pkt_l4,
    input  logic [PORT_W-1:0] pkt_port,
    input  logic [PORT_W-1:0] ref_port,
    input  logic              inv,
    output logic              pass
);
    logic proto_ok;
    logic raw;

    always_comb begin
        proto_ok = sel_udp ? (pkt_l4 == L4_UDP) : (pkt_l4 == L4_TCP);
        raw      = proto_ok && (pkt_port == ref_port);
        pass     = raw ^ inv;
    end

    // R8
    proto_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pkt_l4 == L4_OTHER) || (pkt_l4 == L4_RSVD)) |-> (pass == inv));

endmodule

// File: rtl/l3l4_filt_entry.sv
module l3l4_filt_entry
    import l3l4_filt_pkg::*;
#(
    parameter int ADDR_W = 128,
    parameter int PORT_W = 16,
    parameter int CTRL_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CTRL_W-1:0]   ctrl,
    input  logic [2*PORT_W-1:0] port_word,
    input  logic [ADDR_W-1:0]   addr_word,
    input  logic                pkt_v6,
    input  logic [1:0]          pkt_l4,
    input  logic [ADDR_W-1:0]   pkt_src_addr,
    input  logic [ADDR_W-1:0]   pkt_dst_addr,
    input  logic [PORT_W-1:0]   pkt_src_port,
    input  logic [PORT_W-1:0]   pkt_dst_port,
    output logic                hit,
    output logic                inverting
);
    localparam int V4_W = 32;
    localparam int NDIR = 2;   // 0 = source, 1 = destination

    logic [NDIR-1:0]   a_en, a_inv, a_pass;
    logic [NDIR-1:0]   p_en, p_inv, p_pass;
    logic [MASK_W-1:0] a_k   [NDIR];
    logic [ADDR_W-1:0] a_ref [NDIR];
    logic [ADDR_W-1:0] a_pkt [NDIR];
    logic [PORT_W-1:0] p_ref [NDIR];
    logic [PORT_W-1:0] p_pkt [NDIR];
    logic              mode_v6;
    logic              any_en;
    logic              v6_conflict;
    logic              unused_rsvd;

    assign mode_v6     = ctrl[CB_V6];
    assign unused_rsvd = ^{ctrl[CTRL_W-1:CB_DP_INV+1], ctrl[CB_UDP+1], ctrl[1]};

    always_comb begin
        a_en  = {ctrl[CB_DA_EN],  ctrl[CB_SA_EN]};
        a_inv = {ctrl[CB_DA_INV], ctrl[CB_SA_INV]};
        p_en  = {ctrl[CB_DP_EN],  ctrl[CB_SP_EN]};
        p_inv = {ctrl[CB_DP_INV], ctrl[CB_SP_INV]};
        a_k[0] = ctrl[CB_SMASK_LO +: MASK_W];
        a_k[1] = ctrl[CB_DMASK_LO +: MASK_W];
        a_pkt[0] = pkt_src_addr;
        a_pkt[1] = pkt_dst_addr;
        if (mode_v6) begin
            a_ref[0] = addr_word;
            a_ref[1] = addr_word;
        end else begin
            a_ref[0] = {{(ADDR_W-V4_W){1'b0}}, addr_word[V4_W-1:0]};
            a_ref[1] = {{(ADDR_W-V4_W){1'b0}}, addr_word[2*V4_W-1:V4_W]};
        end
        p_ref[0] = port_word[PORT_W-1:0];
        p_ref[1] = port_word[2*PORT_W-1:PORT_W];
        p_pkt[0] = pkt_src_port;
        p_pkt[1] = pkt_dst_port;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        l3l4_addr_cmp #(.ADDR_W(ADDR_W), .V4_W(V4_W)) u_acmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_v6  (mode_v6),
            .pkt_v6   (pkt_v6),
            .pkt_addr (a_pkt[d]),
            .ref_addr (a_ref[d]),
            .mask_k   (a_k[d]),
            .inv      (a_inv[d]),
            .pass     (a_pass[d])
        );
        l3l4_port_cmp #(.PORT_W(PORT_W)) u_pcmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_udp  (ctrl[CB_UDP]),
            .pkt_l4   (pkt_l4),
            .pkt_port (p_pkt[d]),
            .ref_port (p_ref[d]),
            .inv      (p_inv[d]),
            .pass     (p_pass[d])
        );
    end

    always_comb begin
        any_en      = |{a_en, p_en};
        v6_conflict = mode_v6 && (&a_en);
        hit = any_en && !v6_conflict
              && ((a_pass | ~a_en) == '1)
              && ((p_pass | ~p_en) == '1);
        inverting = |{a_en & a_inv, p_en & p_inv};
    end

    // R3
    zero_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl == '0) |-> !hit);

    // R7
    v6_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CB_V6] && ctrl[CB_SA_EN] && ctrl[CB_DA_EN]) |-> !hit);

    // R9
    src_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CB_SA_EN] && !g_dir[0].u_acmp.pass) |-> !hit);

endmodule

// File: rtl/l3l4_match_filter.sv
module l3l4_match_filter
    import l3l4_filt_pkg::*;
#(
    parameter int NUM_FILT = 4,
    parameter int ADDR_W   = 128,
    parameter int PORT_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [31:0]                cfg_pkt_filter,
    input  logic [NUM_FILT*32-1:0]     cfg_ctrl,
    input  logic [NUM_FILT*32-1:0]     cfg_port,
    input  logic [NUM_FILT*ADDR_W-1:0] cfg_addr,
    input  logic                       pkt_valid,
    input  logic                       pkt_v6,
    input  logic [1:0]                 pkt_l4,
    input  logic [ADDR_W-1:0]          pkt_src_addr,
    input  logic [ADDR_W-1:0]          pkt_dst_addr,
    input  logic [PORT_W-1:0]          pkt_src_port,
    input  logic [PORT_W-1:0]          pkt_dst_port,
    output logic                       res_valid,
    output logic [NUM_FILT-1:0]        res_hit,
    output logic                       res_drop
);
    localparam int CTRL_W = 32;
    localparam int PWORD_W = 2 * PORT_W;

    rep_state_e          state, st_nxt;
    logic [NUM_FILT-1:0] hit_raw;
    logic [NUM_FILT-1:0] inv_vec;
    logic [NUM_FILT-1:0] hit_gated;
    logic                drop_c;
    logic                glob_en;
    logic                unused_pf;

    assign glob_en   = cfg_pkt_filter[GLOBAL_EN_BIT];
    assign unused_pf = ^{cfg_pkt_filter[31:GLOBAL_EN_BIT+1], cfg_pkt_filter[GLOBAL_EN_BIT-1:0]};

    for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
        l3l4_filt_entry #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .CTRL_W(CTRL_W)) u_ent (
            .clk          (clk),
            .rst_n        (rst_n),
            .ctrl         (cfg_ctrl[f*CTRL_W +: CTRL_W]),
            .port_word    (cfg_port[f*PWORD_W +: PWORD_W]),
            .addr_word    (cfg_addr[f*ADDR_W +: ADDR_W]),
            .pkt_v6       (pkt_v6),
            .pkt_l4       (pkt_l4),
            .pkt_src_addr (pkt_src_addr),
            .pkt_dst_addr (pkt_dst_addr),
            .pkt_src_port (pkt_src_port),
            .pkt_dst_port (pkt_dst_port),
            .hit          (hit_raw[f]),
            .inverting    (inv_vec[f])
        );
    end

    always_comb begin
        hit_gated = glob_en ? hit_raw : '0;
        drop_c    = glob_en && (|(inv_vec & ~hit_raw));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= st_nxt;
    end

    always_comb begin
        st_nxt = state;
        unique case (state)
            S_IDLE:   st_nxt = pkt_valid ? S_REPORT : S_IDLE;
            S_REPORT: st_nxt = pkt_valid ? S_REPORT : S_IDLE;
            default:  st_nxt = S_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hit  <= '0;
            res_drop <= 1'b0;
        end else if (pkt_valid) begin
            res_hit  <= hit_gated;
            res_drop <= drop_c;
        end else begin
            res_hit  <= '0;
            res_drop <= 1'b0;
        end
    end

    assign res_valid = (state == S_REPORT);

    // R1
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> res_valid);

    // R1
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_hit == '0 && !res_drop));

    // R2
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !glob_en) |=> (res_hit == '0 && !res_drop));

    // R11
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && pkt_valid) |=> res_valid);

endmodule

// File: tb/sim_l3l4_match_filter.sv
module sim_l3l4_match_filter;
    localparam int NF = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       cfg_pkt_filter = '0;
    logic [NF*32-1:0]  cfg_ctrl = '0;
    logic [NF*32-1:0]  cfg_port = '0;
    logic [NF*128-1:0] cfg_addr = '0;
    logic              pkt_valid = 1'b0;
    logic              pkt_v6 = 1'b0;
    logic [1:0]        pkt_l4 = 2'b00;
    logic [127:0]      pkt_src_addr = '0;
    logic [127:0]      pkt_dst_addr = '0;
    logic [15:0]       pkt_src_port = '0;
    logic [15:0]       pkt_dst_port = '0;
    logic              res_valid;
    logic [NF-1:0]     res_hit;
    logic              res_drop;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    l3l4_match_filter #(.NUM_FILT(NF)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_pkt_filter(cfg_pkt_filter),
        .cfg_ctrl(cfg_ctrl), .cfg_port(cfg_port), .cfg_addr(cfg_addr),
        .pkt_valid(pkt_valid), .pkt_v6(pkt_v6), .pkt_l4(pkt_l4),
        .pkt_src_addr(pkt_src_addr), .pkt_dst_addr(pkt_dst_addr),
        .pkt_src_port(pkt_src_port), .pkt_dst_port(pkt_dst_port),
        .res_valid(res_valid), .res_hit(res_hit), .res_drop(res_drop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit addr_eq(input bit mode, input bit pv6, input logic [127:0] p,
                                   input logic [127:0] r, input int k);
        int top;
        if (mode != pv6) return 1'b0;
        top = mode ? 128 : 32;
        for (int b = 0; b < top; b++)
            if (b >= k && p[b] != r[b]) return 1'b0;
        return 1'b1;
    endfunction

    // returns {inverting, hit} for one entry
    function automatic logic [1:0] ref_entry(input logic [31:0] c, input logic [31:0] pw,
                                             input logic [127:0] aw);
        bit ok, any, v6, sp, dp, sa, da, proto;
        logic [127:0] rs, rd;
        v6 = c[0];
        rs = v6 ? aw : {96'b0, aw[31:0]};
        rd = v6 ? aw : {96'b0, aw[63:32]};
        sa = addr_eq(v6, pkt_v6, pkt_src_addr, rs, int'(c[10:6])) ^ c[3];
        da = addr_eq(v6, pkt_v6, pkt_dst_addr, rd, int'(c[15:11])) ^ c[5];
        proto = c[16] ? (pkt_l4 == 2'b10) : (pkt_l4 == 2'b01);
        sp = (proto && pkt_src_port == pw[15:0]) ^ c[19];
        dp = (proto && pkt_dst_port == pw[31:16]) ^ c[21];
        any = c[2] | c[4] | c[18] | c[20];
        ok = any && !(v6 && c[2] && c[4]);
        if (c[2] && !sa) ok = 1'b0;
        if (c[4] && !da) ok = 1'b0;
        if (c[18] && !sp) ok = 1'b0;
        if (c[20] && !dp) ok = 1'b0;
        return {(c[2]&c[3]) | (c[4]&c[5]) | (c[18]&c[19]) | (c[20]&c[21]), ok};
    endfunction

    task automatic expect_now(output logic [NF-1:0] eh, output logic ed);
        logic [1:0] r;
        eh = '0; ed = 1'b0;
        for (int f = 0; f < NF; f++) begin
            r = ref_entry(cfg_ctrl[f*32 +: 32], cfg_port[f*32 +: 32], cfg_addr[f*128 +: 128]);
            if (cfg_pkt_filter[20]) begin
                eh[f] = r[0];
                if (r[1] && !r[0]) ed = 1'b1;
            end
        end
    endtask

    // Packet fields set by caller; strobes, waits one cycle, checks
    task automatic send(input string req);
        logic [NF-1:0] eh;
        logic ed;
        expect_now(eh, ed);
        pkt_valid = 1'b1;
        @(negedge clk);
        check({req, " valid"}, 32'(res_valid), 32'd1);
        check({req, " hit"},   32'(res_hit),   32'(eh));
        check({req, " drop"},  32'(res_drop),  32'(ed));
    endtask

    task automatic idle_check(input string req);
        pkt_valid = 1'b0;
        @(negedge clk);
        check({req, " idle"}, {30'b0, res_valid, res_drop} | 32'(res_hit), 32'd0);
    endtask

    task automatic set_v4(input logic [31:0] s, input logic [31:0] d, input logic [1:0] l4,
                          input logic [15:0] sp, input logic [15:0] dp);
        pkt_v6 = 1'b0; pkt_l4 = l4;
        pkt_src_addr = {96'b0, s}; pkt_dst_addr = {96'b0, d};
        pkt_src_port = sp; pkt_dst_port = dp;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic rand_cfg();
        logic [31:0] c;
        for (int f = 0; f < NF; f++) begin
            c = '0;
            if ($urandom % 6 != 0) begin
                c[0] = $urandom % 3 == 0;
                c[2] = $urandom % 2; c[3] = $urandom % 4 == 0;
                c[4] = $urandom % 2; c[5] = $urandom % 4 == 0;
                c[10:6]  = 5'($urandom % 6);
                c[15:11] = 5'($urandom % 6);
                c[16] = $urandom % 2;
                c[18] = $urandom % 3 == 0; c[19] = $urandom % 4 == 0;
                c[20] = $urandom % 3 == 0; c[21] = $urandom % 4 == 0;
            end
            cfg_ctrl[f*32 +: 32]   = c;
            cfg_port[f*32 +: 32]   = $urandom;
            cfg_addr[f*128 +: 128] = rnd128();
        end
        cfg_pkt_filter = ($urandom % 8 == 0) ? 32'h0 : (32'h0010_0000 | ($urandom & 32'hFFEF_FFFF));
    endtask

    task automatic rand_pkt();
        int f;
        logic [31:0] c;
        logic [127:0] aw;
        logic [31:0] pw;
        f  = int'($urandom % NF);
        c  = cfg_ctrl[f*32 +: 32];
        aw = cfg_addr[f*128 +: 128];
        pw = cfg_port[f*32 +: 32];
        if ($urandom % 4 != 0) begin
            pkt_v6 = ($urandom % 8 == 0) ? ~c[0] : c[0];
            pkt_src_addr = c[0] ? aw : {rnd128() >> 32, aw[31:0]};
            pkt_dst_addr = c[0] ? aw : {rnd128() >> 32, aw[63:32]};
            pkt_src_addr[5:0] ^= 6'($urandom % 64 & ($urandom % 2 ? 63 : 0));
            pkt_dst_addr[5:0] ^= 6'($urandom % 64 & ($urandom % 2 ? 63 : 0));
            pkt_l4 = ($urandom % 8 == 0) ? 2'($urandom) : (c[16] ? 2'b10 : 2'b01);
            pkt_src_port = ($urandom % 6 == 0) ? 16'($urandom) : pw[15:0];
            pkt_dst_port = ($urandom % 6 == 0) ? 16'($urandom) : pw[31:16];
        end else begin
            pkt_v6 = $urandom % 2;
            pkt_src_addr = rnd128(); pkt_dst_addr = rnd128();
            pkt_l4 = 2'($urandom);
            pkt_src_port = 16'($urandom); pkt_dst_port = 16'($urandom);
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int seed_init;
        seed_init = $urandom(32'h1A2B3C);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset", {30'b0, res_valid, res_drop} | 32'(res_hit), 32'd0);

        // Filter 0: IPv4 source match 10.0.0.1, others zero (R3)
        cfg_ctrl[31:0]  = 32'h0000_0004;
        cfg_addr[127:0] = {64'b0, 32'hC0A8_0001, 32'h0A00_0001};
        cfg_pkt_filter  = 32'h0;
        set_v4(32'h0A00_0001, 32'h1, 2'b01, 16'd1, 16'd2);
        send("R2 global off");
        check("R2 hit zero", 32'(res_hit), 32'd0);
        idle_check("R1");

        cfg_pkt_filter = 32'h0010_0000;
        send("R4 v4 src match");
        check("R4 entry0", 32'(res_hit[0]), 32'd1);
        check("R3 zero entries", 32'(res_hit[NF-1:1]), 32'd0);
        pkt_v6 = 1'b1;
        send("R4 version mismatch");
        check("R4 v6 pkt on v4 entry", 32'(res_hit[0]), 32'd0);

        // R5 mask counts
        set_v4(32'h0A00_000E, 32'h1, 2'b01, 16'd1, 16'd2);
        cfg_ctrl[31:0] = 32'h0000_0004 | (32'd4 << 6);
        send("R5 mask4");
        check("R5 mask4 hit", 32'(res_hit[0]), 32'd1);
        cfg_ctrl[31:0] = 32'h0000_0004 | (32'd3 << 6);
        send("R5 mask3");
        check("R5 mask3 miss", 32'(res_hit[0]), 32'd0);

        // R4 destination uses word bits [63:32]
        cfg_ctrl[31:0] = 32'h0000_0010;
        set_v4(32'h0, 32'hC0A8_0001, 2'b01, 16'd1, 16'd2);
        send("R4 v4 dst");
        check("R4 dst hit", 32'(res_hit[0]), 32'd1);

        // R6 / R10 inversion and drop
        cfg_ctrl[31:0] = 32'h0000_000C;
        set_v4(32'h0A00_0001, 32'h0, 2'b01, 16'd1, 16'd2);
        send("R6 inverted match");
        check("R10 drop on inverted miss", 32'(res_drop), 32'd1);
        pkt_src_addr = 128'h0A00_0002;
        send("R6 inverted pass");
        check("R10 no drop", 32'(res_drop), 32'd0);

        // R7 IPv6 dual enable
        cfg_ctrl[31:0] = 32'h0000_0015;
        cfg_addr[127:0] = 128'h2001_0db8_0000_0000_0000_0000_0000_0042;
        pkt_v6 = 1'b1; pkt_src_addr = cfg_addr[127:0]; pkt_dst_addr = cfg_addr[127:0];
        send("R7 v6 both");
        check("R7 no hit", 32'(res_hit[0]), 32'd0);
        cfg_ctrl[31:0] = 32'h0000_0005;
        send("R4 v6 src full");
        check("R4 v6 hit", 32'(res_hit[0]), 32'd1);

        // R8 ports: UDP dst 0x1234
        cfg_ctrl[31:0] = 32'h0011_0000;
        cfg_port[31:0] = 32'h1234_5678;
        set_v4(32'h0, 32'h0, 2'b10, 16'h0, 16'h1234);
        send("R8 udp dst");
        check("R8 udp hit", 32'(res_hit[0]), 32'd1);
        pkt_l4 = 2'b01;
        send("R8 tcp on udp");
        check("R8 proto miss", 32'(res_hit[0]), 32'd0);

        // R9 combined: port ok, address fails
        cfg_ctrl[31:0] = 32'h0011_0004;
        cfg_addr[127:0] = 128'h0A00_0001;
        set_v4(32'h0A00_0009, 32'h0, 2'b10, 16'h0, 16'h1234);
        send("R9 partial");
        check("R9 miss", 32'(res_hit[0]), 32'd0);

        // R3 nonzero ctrl without enables
        cfg_ctrl[31:0] = 32'h0001_0001;
        send("R3 no enables");
        check("R3 miss", 32'(res_hit[0]), 32'd0);

        // R11 back to back
        cfg_ctrl[31:0] = 32'h0000_0004;
        set_v4(32'h0A00_0001, 32'h0, 2'b01, 16'd1, 16'd2);
        send("R11 first");
        pkt_src_addr = 128'h0A00_0003;
        send("R11 second");
        check("R11 second miss", 32'(res_hit[0]), 32'd0);
        idle_check("R1 after burst");

        // Random mix (R4 R5 R6 R8 R9 R10)
        for (int i = 0; i < 600; i++) begin
            if (i % 40 == 0) rand_cfg();
            rand_pkt();
            send("R9 random");
            if ($urandom % 3 == 0) idle_check("R1 random");
        end

        pkt_valid = 1'b0;
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule